// File: doc/BRIEF.md
# Machine-Mode Control and Status Register Unit

This block holds the machine-level control and status registers of a single-hart, 32-bit core that runs only in machine mode. Each cycle the core may present one register-access request: a 12-bit register address, a 3-bit operation code, a source value and a 5-bit source index. The index is either the source register number or, for the immediate forms, the 5-bit immediate. The unit returns the register's current contents in the same cycle and flags the access as illegal when needed. The new value is committed at the next clock edge.

The unit also owns the trap machinery. A trap request carries the faulting or interrupted pc, a cause code and an interrupt flag. The unit returns the redirect target in the same cycle and, at the clock edge, saves the pc, the cause and the interrupt-enable history. A return request restores the enable bit, and the saved pc is always presented as the return target. Three level inputs report pending software, timer and external interrupts. The unit combines them with the enable registers and reports whether an interrupt should be taken and with which cause. Two 64-bit counters, one for cycles and one for retired instructions, run inside the unit. An external 64-bit real-time value is shadowed for reads.

Top module: `mcsr_unit`

## Requirements
- R1: Operation codes are: 001 write, 010 set, 011 clear, 101 write-immediate, 110 set-immediate, 111 clear-immediate. Immediate forms use the 5-bit index zero-extended as the operand. csr_rdata always shows the value held before the access is committed.
- R2: Set and clear forms (010, 011, 110, 111) whose index is zero perform no write. This holds even when the source value is non-zero, and such an access to a read-only register is legal.
- R3: csr_illegal rises, and no register changes, for any of these: an address that is not implemented, an operation code of 000 or 100, or a writing access to a read-only register. Read-only registers are all addresses with bits [11:10] = 11 and the trap vector register 0x305.
- R4: The status register 0x300 holds two writable bits: bit 3 is the global interrupt enable and bit 7 is the saved enable. Bits 12:11 always read 11, and every other bit reads 0 (reset value 0x1800).
- R5: The interrupt-enable register 0x304 keeps only bits 3, 7 and 11. The pending register 0x344 shows the software, timer and external inputs at bits 3, 7 and 11, and writes to it have no effect.
- R6: The exception pc register 0x341 clears bits [1:0] on every write. The scratch register 0x340 keeps all 32 bits.
- R7: These addresses read zero and ignore legal writes: 0x301, 0x310, 0x343, 0x323-0x33F and 0xB03-0xB1F / 0xB83-0xB9F. These read-only addresses read zero: 0xF11-0xF15, 0xC03-0xC1F and 0xC83-0xC9F.
- R8: A trap request takes effect at the next edge. It sets the exception pc to trap_pc with bits [1:0] cleared, and sets the cause register to trap_cause with bit 31 equal to trap_irq. It copies the enable bit into the saved-enable bit and clears the enable bit.
- R9: Register 0x305 reads VEC_BASE | 1. trap_target equals VEC_BASE for exceptions and VEC_BASE + 4*trap_cause for interrupts; with the default base, causes 3, 7 and 11 give 0x14, 0x24 and 0x34.
- R10: A return request copies the saved-enable bit into the enable bit and sets the saved-enable bit. mret_target always equals the exception pc register.
- R11: irq_take is 1 only when the enable bit is set and some bit is set in both the enable and pending registers. irq_cause gives the highest-priority such source, in the order external (11), software (3), timer (7).
- R12: The cycle counter (0xB00 low, 0xB80 high) advances every cycle, and the retired counter (0xB02, 0xB82) advances when retire is high. Carries pass from the low half into the high half. 0xC00/0xC80/0xC02/0xC82 are read-only copies of these counters, and 0xC01/0xC81 read the low and high halves of mtime_in.
- R13: A committed write to either half of a counter replaces that counter's automatic increment for that cycle.
- R14: When a trap or return request coincides with a register write, the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_req | input | 1 | Register access request valid |
| csr_op | input | 3 | Operation code |
| csr_addr | input | 12 | Register address |
| csr_src_val | input | 32 | Source register value |
| csr_src_idx | input | 5 | Source register index or 5-bit immediate |
| csr_rdata | output | 32 | Current value of the addressed register |
| csr_illegal | output | 1 | Access is illegal |
| retire | input | 1 | One instruction retires this cycle |
| trap_req | input | 1 | Trap entry request |
| trap_pc | input | 32 | pc of the trapping instruction |
| trap_cause | input | 5 | Trap cause code |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_target | output | 32 | Handler address for the trap request |
| mret_req | input | 1 | Trap return request |
| mret_target | output | 32 | Return address (saved exception pc) |
| irq_sw_in | input | 1 | Software interrupt pending level |
| irq_tmr_in | input | 1 | Timer interrupt pending level |
| irq_ext_in | input | 1 | External interrupt pending level |
| irq_take | output | 1 | An enabled interrupt is pending |
| irq_cause | output | 5 | Cause code of the interrupt to take |
| mtime_in | input | 64 | External real-time counter value |

## Verification
The hardest case to reach from the ports is a counter carrying from its low half into its high half while writes compete with the automatic increment. The bench gets there by writing the high half and then the low half on back-to-back cycles, to values just below the wrap point. It then reads the halves on the following cycles and checks that both writes suppressed the increment and that the carry arrived exactly one cycle later. A second hard case is a trap in the same cycle as a scratch-register write. The bench drives both requests in one cycle, then reads the scratch register, the exception pc and the status register.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

  // register read/write selection produced by the address decoder
  typedef enum logic [3:0] {
    SEL_ZERO,
    SEL_STATUS,
    SEL_IEN,
    SEL_IPEND,
    SEL_TVEC,
    SEL_EPC,
    SEL_CAUSE,
    SEL_SCRATCH,
    SEL_CYC_LO,
    SEL_CYC_HI,
    SEL_RET_LO,
    SEL_RET_HI,
    SEL_TIME_LO,
    SEL_TIME_HI
  } csr_sel_e;

  // operation code low bits: 01 write, 10 set, 11 clear; bit 2 selects immediate
  localparam logic [1:0] OPK_WRITE = 2'b01;
  localparam logic [1:0] OPK_SET   = 2'b10;
  localparam logic [1:0] OPK_CLEAR = 2'b11;
  localparam int unsigned OP_IMM_BIT = 2;

  // status register field positions
  localparam int unsigned ST_EN_BIT   = 3;
  localparam int unsigned ST_PEN_BIT  = 7;
  localparam int unsigned ST_MODE_LO  = 11;
  localparam int unsigned ST_MODE_HI  = 12;

  // interrupt line positions in the enable/pending registers
  localparam int unsigned IRQ_SW_BIT  = 3;
  localparam int unsigned IRQ_TMR_BIT = 7;
  localparam int unsigned IRQ_EXT_BIT = 11;

  // counter indices
  localparam int unsigned CNT_CYC = 0;
  localparam int unsigned CNT_RET = 1;
  localparam int unsigned NUM_CNT = 2;

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
(
  input  logic [11:0] addr,
  output logic        present,
  output logic        read_only,
  output csr_sel_e    sel
);

  always_comb begin
    present   = 1'b1;
    read_only = (addr[11:10] == 2'b11);
    sel       = SEL_ZERO;
    case (addr)
      12'h300: sel = SEL_STATUS;
      12'h304: sel = SEL_IEN;
      12'h344: sel = SEL_IPEND;
      12'h305: begin
        sel       = SEL_TVEC;
        read_only = 1'b1;
      end
      12'h341: sel = SEL_EPC;
      12'h342: sel = SEL_CAUSE;
      12'h340: sel = SEL_SCRATCH;
      12'hB00, 12'hC00: sel = SEL_CYC_LO;
      12'hB80, 12'hC80: sel = SEL_CYC_HI;
      12'hB02, 12'hC02: sel = SEL_RET_LO;
      12'hB82, 12'hC82: sel = SEL_RET_HI;
      12'hC01: sel = SEL_TIME_LO;
      12'hC81: sel = SEL_TIME_HI;
      12'h301, 12'h310, 12'h343: sel = SEL_ZERO;
      default: begin
        sel = SEL_ZERO;
        if (!(addr inside {[12'hF11:12'hF15],
                           [12'h323:12'h33F],
                           [12'hB03:12'hB1F], [12'hB83:12'hB9F],
                           [12'hC03:12'hC1F], [12'hC83:12'hC9F]})) begin
          present = 1'b0;
        end
      end
    endcase
  end

endmodule

// File: rtl/mcsr_counter.sv
module mcsr_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [CNT_W/2-1:0] wr_data,
  output logic [CNT_W-1:0]   cnt_q
);

  localparam int unsigned HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  // a software write replaces the automatic increment for this cycle
  always_comb begin
    cnt_n = cnt_q;
    if (wr_lo) begin
      cnt_n[HALF-1:0] = wr_data;
    end else if (wr_hi) begin
      cnt_n[CNT_W-1:HALF] = wr_data;
    end else if (inc) begin
      cnt_n = cnt_q + ONE;
    end
  end

  assign cnt_en = wr_lo | wr_hi | inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/mcsr_state.sv
module mcsr_state
  import mcsr_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  csr_sel_e           wr_sel,
  input  logic [XLEN-1:0]    wr_data,
  input  logic               trap_req,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic               trap_irq,
  input  logic               mret_req,
  output logic               st_en,
  output logic               st_pen,
  output logic [XLEN-1:0]    ien_q,
  output logic [XLEN-1:0]    epc_q,
  output logic [XLEN-1:0]    cause_q,
  output logic [XLEN-1:0]    scratch_q
);

  localparam logic [XLEN-1:0] EPC_MASK = ~{{(XLEN-2){1'b0}}, 2'b11};
  localparam logic [XLEN-1:0] IEN_MASK = (XLEN'(1) << IRQ_SW_BIT)
                                       | (XLEN'(1) << IRQ_TMR_BIT)
                                       | (XLEN'(1) << IRQ_EXT_BIT);

  logic            st_en_n, st_pen_n;
  logic [XLEN-1:0] ien_n, epc_n, cause_n, scratch_n;
  logic            upd_en;

  always_comb begin
    st_en_n   = st_en;
    st_pen_n  = st_pen;
    ien_n     = ien_q;
    epc_n     = epc_q;
    cause_n   = cause_q;
    scratch_n = scratch_q;
    if (trap_req) begin
      epc_n    = trap_pc & EPC_MASK;
      cause_n  = {trap_irq, {(XLEN-1-CAUSE_W){1'b0}}, trap_cause};
      st_pen_n = st_en;
      st_en_n  = 1'b0;
    end else if (mret_req) begin
      st_en_n  = st_pen;
      st_pen_n = 1'b1;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_STATUS: begin
          st_en_n  = wr_data[ST_EN_BIT];
          st_pen_n = wr_data[ST_PEN_BIT];
        end
        SEL_IEN:     ien_n     = wr_data & IEN_MASK;
        SEL_EPC:     epc_n     = wr_data & EPC_MASK;
        SEL_CAUSE:   cause_n   = wr_data;
        SEL_SCRATCH: scratch_n = wr_data;
        default: ;
      endcase
    end
  end

  assign upd_en = trap_req | mret_req | wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_en     <= 1'b0;
      st_pen    <= 1'b0;
      ien_q     <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
      scratch_q <= '0;
    end else if (upd_en) begin
      st_en     <= st_en_n;
      st_pen    <= st_pen_n;
      ien_q     <= ien_n;
      epc_q     <= epc_n;
      cause_q   <= cause_n;
      scratch_q <= scratch_n;
    end
  end

endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
#(
  parameter int unsigned         XLEN     = 32,
  parameter int unsigned         CNT_W    = 64,
  parameter int unsigned         CAUSE_W  = 5,
  parameter logic [XLEN-1:0]     VEC_BASE = 32'h0000_0008
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_req,
  input  logic [2:0]         csr_op,
  input  logic [11:0]        csr_addr,
  input  logic [XLEN-1:0]    csr_src_val,
  input  logic [4:0]         csr_src_idx,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               csr_illegal,
  input  logic               retire,
  input  logic               trap_req,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic               trap_irq,
  output logic [XLEN-1:0]    trap_target,
  input  logic               mret_req,
  output logic [XLEN-1:0]    mret_target,
  input  logic               irq_sw_in,
  input  logic               irq_tmr_in,
  input  logic               irq_ext_in,
  output logic               irq_take,
  output logic [CAUSE_W-1:0] irq_cause,
  input  logic [CNT_W-1:0]   mtime_in
);

  localparam int unsigned HALF = CNT_W / 2;
  localparam logic [XLEN-1:0] TVEC_VALUE = VEC_BASE | XLEN'(1);

  // ---------------- access decode ----------------
  logic     addr_present, addr_ro;
  csr_sel_e sel;

  mcsr_decode u_decode (
    .addr      (csr_addr),
    .present   (addr_present),
    .read_only (addr_ro),
    .sel       (sel)
  );

  logic [1:0]      op_kind;
  logic            op_imm, op_valid, wants_write;
  logic [XLEN-1:0] operand, wr_value;
  logic            wr_commit;

  assign op_kind     = csr_op[1:0];
  assign op_imm      = csr_op[OP_IMM_BIT];
  assign op_valid    = (op_kind != 2'b00);
  assign operand     = op_imm ? {{(XLEN-5){1'b0}}, csr_src_idx} : csr_src_val;
  assign wants_write = (op_kind == OPK_WRITE) | (csr_src_idx != 5'd0);
  assign csr_illegal = csr_req & (!op_valid | !addr_present | (wants_write & addr_ro));
  assign wr_commit   = csr_req & !csr_illegal & wants_write & !trap_req & !mret_req;

  always_comb begin
    case (op_kind)
      OPK_SET:   wr_value = csr_rdata | operand;
      OPK_CLEAR: wr_value = csr_rdata & ~operand;
      default:   wr_value = operand;
    endcase
  end

  // ---------------- trap and status state ----------------
  logic            st_en, st_pen;
  logic [XLEN-1:0] ien_q, epc_q, cause_q, scratch_q;

  mcsr_state #(
    .XLEN    (XLEN),
    .CAUSE_W (CAUSE_W)
  ) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_commit),
    .wr_sel     (sel),
    .wr_data    (wr_value),
    .trap_req   (trap_req),
    .trap_pc    (trap_pc),
    .trap_cause (trap_cause),
    .trap_irq   (trap_irq),
    .mret_req   (mret_req),
    .st_en      (st_en),
    .st_pen     (st_pen),
    .ien_q      (ien_q),
    .epc_q      (epc_q),
    .cause_q    (cause_q),
    .scratch_q  (scratch_q)
  );

  // ---------------- counters ----------------
  logic [NUM_CNT-1:0] cnt_inc, cnt_wr_lo, cnt_wr_hi;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];

  assign cnt_inc[CNT_CYC]   = 1'b1;
  assign cnt_inc[CNT_RET]   = retire;
  assign cnt_wr_lo[CNT_CYC] = wr_commit & (sel == SEL_CYC_LO);
  assign cnt_wr_hi[CNT_CYC] = wr_commit & (sel == SEL_CYC_HI);
  assign cnt_wr_lo[CNT_RET] = wr_commit & (sel == SEL_RET_LO);
  assign cnt_wr_hi[CNT_RET] = wr_commit & (sel == SEL_RET_HI);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    mcsr_counter #(
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (cnt_inc[g]),
      .wr_lo   (cnt_wr_lo[g]),
      .wr_hi   (cnt_wr_hi[g]),
      .wr_data (wr_value[HALF-1:0]),
      .cnt_q   (cnt_val[g])
    );
  end

  // signals brought out for the bound checker
  logic [CNT_W-1:0] cyc_now;
  logic             cyc_wr;
  assign cyc_now = cnt_val[CNT_CYC];
  assign cyc_wr  = cnt_wr_lo[CNT_CYC] | cnt_wr_hi[CNT_CYC];

  // ---------------- interrupts ----------------
  logic [XLEN-1:0] ipend_vec, ready_vec;

  always_comb begin
    ipend_vec              = '0;
    ipend_vec[IRQ_SW_BIT]  = irq_sw_in;
    ipend_vec[IRQ_TMR_BIT] = irq_tmr_in;
    ipend_vec[IRQ_EXT_BIT] = irq_ext_in;
  end

  assign ready_vec = ien_q & ipend_vec;
  assign irq_take  = st_en & (|ready_vec);

  always_comb begin
    if (ready_vec[IRQ_EXT_BIT])     irq_cause = CAUSE_W'(IRQ_EXT_BIT);
    else if (ready_vec[IRQ_SW_BIT]) irq_cause = CAUSE_W'(IRQ_SW_BIT);
    else                            irq_cause = CAUSE_W'(IRQ_TMR_BIT);
  end

  // ---------------- trap redirect ----------------
  assign trap_target = trap_irq
                     ? VEC_BASE + {{(XLEN-CAUSE_W-2){1'b0}}, trap_cause, 2'b00}
                     : VEC_BASE;
  assign mret_target = epc_q;

  // ---------------- read mux ----------------
  logic [XLEN-1:0] status_word;

  always_comb begin
    status_word                        = '0;
    status_word[ST_MODE_HI:ST_MODE_LO] = 2'b11;
    status_word[ST_EN_BIT]             = st_en;
    status_word[ST_PEN_BIT]            = st_pen;
  end

  always_comb begin
    case (sel)
      SEL_STATUS:  csr_rdata = status_word;
      SEL_IEN:     csr_rdata = ien_q;
      SEL_IPEND:   csr_rdata = ipend_vec;
      SEL_TVEC:    csr_rdata = TVEC_VALUE;
      SEL_EPC:     csr_rdata = epc_q;
      SEL_CAUSE:   csr_rdata = cause_q;
      SEL_SCRATCH: csr_rdata = scratch_q;
      SEL_CYC_LO:  csr_rdata = cnt_val[CNT_CYC][HALF-1:0];
      SEL_CYC_HI:  csr_rdata = cnt_val[CNT_CYC][CNT_W-1:HALF];
      SEL_RET_LO:  csr_rdata = cnt_val[CNT_RET][HALF-1:0];
      SEL_RET_HI:  csr_rdata = cnt_val[CNT_RET][CNT_W-1:HALF];
      SEL_TIME_LO: csr_rdata = mtime_in[HALF-1:0];
      SEL_TIME_HI: csr_rdata = mtime_in[CNT_W-1:HALF];
      default:     csr_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mcsr_unit_chk.sv
module mcsr_unit_chk #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned CAUSE_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               csr_req,
  input logic               csr_illegal,
  input logic               trap_req,
  input logic [XLEN-1:0]    trap_pc,
  input logic               mret_req,
  input logic [XLEN-1:0]    mret_target,
  input logic               st_en,
  input logic               st_pen,
  input logic [XLEN-1:0]    scratch_q,
  input logic [XLEN-1:0]    ien_q,
  input logic [CNT_W-1:0]   cyc_now,
  input logic               cyc_wr,
  input logic               irq_take,
  input logic [CAUSE_W-1:0] irq_cause
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_trap_epc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> mret_target == ($past(trap_pc) & ~XLEN'(3)));

  assert_trap_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (!st_en && st_pen == $past(st_en)));

  assert_return_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_req && !trap_req) |=> (st_pen && st_en == $past(st_pen)));

  assert_illegal_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_illegal) |=> ($stable(scratch_q) && $stable(ien_q)));

  assert_cycle_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(cyc_wr)) |-> cyc_now == $past(cyc_now) + CNT_W'(1));

  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_cause == CAUSE_W'(3) || irq_cause == CAUSE_W'(7) || irq_cause == CAUSE_W'(11)));

endmodule

bind mcsr_unit mcsr_unit_chk #(
  .XLEN    (XLEN),
  .CNT_W   (CNT_W),
  .CAUSE_W (CAUSE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_req     (csr_req),
  .csr_illegal (csr_illegal),
  .trap_req    (trap_req),
  .trap_pc     (trap_pc),
  .mret_req    (mret_req),
  .mret_target (mret_target),
  .st_en       (st_en),
  .st_pen      (st_pen),
  .scratch_q   (scratch_q),
  .ien_q       (ien_q),
  .cyc_now     (cyc_now),
  .cyc_wr      (cyc_wr),
  .irq_take    (irq_take),
  .irq_cause   (irq_cause)
);

// File: tb/mcsr_unit_bench.sv
module mcsr_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        csr_req;
  logic [2:0]  csr_op;
  logic [11:0] csr_addr;
  logic [31:0] csr_src_val;
  logic [4:0]  csr_src_idx;
  logic [31:0] csr_rdata;
  logic        csr_illegal;
  logic        retire;
  logic        trap_req;
  logic [31:0] trap_pc;
  logic [4:0]  trap_cause;
  logic        trap_irq;
  logic [31:0] trap_target;
  logic        mret_req;
  logic [31:0] mret_target;
  logic        irq_sw_in, irq_tmr_in, irq_ext_in;
  logic        irq_take;
  logic [4:0]  irq_cause;
  logic [63:0] mtime_in;

  mcsr_unit u_mcsr_unit (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_op(csr_op),
    .csr_addr(csr_addr), .csr_src_val(csr_src_val), .csr_src_idx(csr_src_idx),
    .csr_rdata(csr_rdata), .csr_illegal(csr_illegal), .retire(retire),
    .trap_req(trap_req), .trap_pc(trap_pc), .trap_cause(trap_cause),
    .trap_irq(trap_irq), .trap_target(trap_target), .mret_req(mret_req),
    .mret_target(mret_target), .irq_sw_in(irq_sw_in), .irq_tmr_in(irq_tmr_in),
    .irq_ext_in(irq_ext_in), .irq_take(irq_take), .irq_cause(irq_cause),
    .mtime_in(mtime_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] cap_rd, cap_tt, cap_mt;
  logic        cap_ill, cap_take;
  logic [4:0]  cap_cause;

  localparam logic [2:0] W = 3'b001, S = 3'b010, C = 3'b011;
  localparam logic [2:0] WI = 3'b101, SI = 3'b110, CI = 3'b111;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic capture();
    #2;
    cap_rd    = csr_rdata;
    cap_ill   = csr_illegal;
    cap_take  = irq_take;
    cap_cause = irq_cause;
    cap_tt    = trap_target;
    cap_mt    = mret_target;
    @(posedge clk);
  endtask

  task automatic step(input logic [2:0] op, input logic [11:0] addr,
                      input logic [31:0] val, input logic [4:0] idx, input logic ret);
    @(negedge clk);
    csr_req = 1'b1; csr_op = op; csr_addr = addr; csr_src_val = val; csr_src_idx = idx;
    retire = ret; trap_req = 1'b0; mret_req = 1'b0;
    capture();
  endtask

  task automatic rd(input logic [11:0] addr);
    step(S, addr, 32'hFFFF_FFFF, 5'd0, 1'b0);
  endtask

  task automatic idle();
    @(negedge clk);
    csr_req = 1'b0; retire = 1'b0; trap_req = 1'b0; mret_req = 1'b0;
    capture();
  endtask

  task automatic do_trap(input logic [31:0] pc, input logic [4:0] cause, input logic irq,
                         input logic with_wr, input logic [31:0] wval);
    @(negedge clk);
    csr_req = with_wr; csr_op = W; csr_addr = 12'h340; csr_src_val = wval; csr_src_idx = 5'd1;
    retire = 1'b0; mret_req = 1'b0;
    trap_req = 1'b1; trap_pc = pc; trap_cause = cause; trap_irq = irq;
    capture();
  endtask

  task automatic do_mret();
    @(negedge clk);
    csr_req = 1'b0; retire = 1'b0; trap_req = 1'b0; mret_req = 1'b1;
    capture();
  endtask

  task automatic set_irq(input logic sw, input logic tm, input logic ex);
    @(negedge clk);
    irq_sw_in = sw; irq_tmr_in = tm; irq_ext_in = ex;
    csr_req = 1'b0; retire = 1'b0; trap_req = 1'b0; mret_req = 1'b0;
    @(posedge clk);
  endtask

  task automatic t_reset();
    rd(12'h300); chk("R4 reset status", cap_rd, 32'h0000_1800);
    rd(12'h340); chk("R6 reset scratch", cap_rd, 32'h0);
    chk("R11 reset no irq", cap_take, 1'b0);
  endtask

  task automatic t_ops();
    step(W, 12'h340, 32'hA5A5_0F0F, 5'd4, 1'b0); chk("R1 write returns old", cap_rd, 32'h0);
    step(S, 12'h340, 32'h0000_00F0, 5'd5, 1'b0); chk("R1 set returns old", cap_rd, 32'hA5A5_0F0F);
    rd(12'h340); chk("R1 set result", cap_rd, 32'hA5A5_0FFF);
    step(C, 12'h340, 32'hA500_0000, 5'd5, 1'b0);
    rd(12'h340); chk("R1 clear result", cap_rd, 32'h00A5_0FFF);
    step(WI, 12'h340, 32'hFFFF_FFFF, 5'h1F, 1'b0);
    rd(12'h340); chk("R1 write-imm zero-extends", cap_rd, 32'h0000_001F);
    step(CI, 12'h340, 32'hFFFF_FFFF, 5'd3, 1'b0);
    rd(12'h340); chk("R1 clear-imm", cap_rd, 32'h0000_001C);
    step(SI, 12'h340, 32'h0, 5'd1, 1'b0);
    rd(12'h340); chk("R1 set-imm", cap_rd, 32'h0000_001D);
    step(S, 12'h340, 32'hFFFF_FFFF, 5'd0, 1'b0);
    rd(12'h340); chk("R2 set idx0 no write", cap_rd, 32'h0000_001D);
    step(C, 12'h340, 32'hFFFF_FFFF, 5'd0, 1'b0);
    rd(12'h340); chk("R2 clear idx0 no write", cap_rd, 32'h0000_001D);
    step(CI, 12'h340, 32'h0, 5'd0, 1'b0);
    rd(12'h340); chk("R2 clear-imm 0 no write", cap_rd, 32'h0000_001D);
  endtask

  task automatic t_illegal();
    step(W, 12'hC00, 32'h1, 5'd1, 1'b0); chk("R3 write shadow illegal", cap_ill, 1'b1);
    step(S, 12'hC00, 32'h1, 5'd0, 1'b0); chk("R2 read shadow legal", cap_ill, 1'b0);
    step(W, 12'h305, 32'h0, 5'd1, 1'b0); chk("R3 write vector illegal", cap_ill, 1'b1);
    rd(12'h305); chk("R9 vector value", cap_rd, 32'h0000_0009);
    chk("R3 vector read legal", cap_ill, 1'b0);
    rd(12'h7C0); chk("R3 absent read illegal", cap_ill, 1'b1);
    rd(12'hB01); chk("R3 absent counter gap illegal", cap_ill, 1'b1);
    step(3'b000, 12'h340, 32'hDEAD_BEEF, 5'd1, 1'b0); chk("R3 op 000 illegal", cap_ill, 1'b1);
    step(3'b100, 12'h340, 32'hDEAD_BEEF, 5'd1, 1'b0); chk("R3 op 100 illegal", cap_ill, 1'b1);
    rd(12'h340); chk("R3 no state change", cap_rd, 32'h0000_001D);
    step(S, 12'hF12, 32'h0, 5'd2, 1'b0); chk("R3 set on id reg illegal", cap_ill, 1'b1);
  endtask

  task automatic t_fields();
    step(W, 12'h300, 32'hFFFF_FFFF, 5'd1, 1'b0);
    rd(12'h300); chk("R4 status writable bits", cap_rd, 32'h0000_1888);
    step(W, 12'h300, 32'h0, 5'd1, 1'b0);
    rd(12'h300); chk("R4 status cleared", cap_rd, 32'h0000_1800);
    step(W, 12'h304, 32'hFFFF_FFFF, 5'd1, 1'b0);
    rd(12'h304); chk("R5 enable mask", cap_rd, 32'h0000_0888);
    set_irq(1'b1, 1'b1, 1'b0);
    rd(12'h344); chk("R5 pending view", cap_rd, 32'h0000_0088);
    step(W, 12'h344, 32'h0, 5'd1, 1'b0); chk("R5 pending write legal", cap_ill, 1'b0);
    rd(12'h344); chk("R5 pending write ignored", cap_rd, 32'h0000_0088);
    step(W, 12'h341, 32'h2000_0107, 5'd1, 1'b0);
    rd(12'h341); chk("R6 epc aligned", cap_rd, 32'h2000_0104);
    step(W, 12'h301, 32'hFFFF_FFFF, 5'd1, 1'b0);
    rd(12'h301); chk("R7 isa reg zero", cap_rd, 32'h0);
    step(W, 12'h343, 32'hFFFF_FFFF, 5'd1, 1'b0);
    rd(12'h343); chk("R7 tval zero", cap_rd, 32'h0);
    step(W, 12'hB05, 32'h1234, 5'd1, 1'b0); chk("R7 hpm write legal", cap_ill, 1'b0);
    rd(12'hB05); chk("R7 hpm reads zero", cap_rd, 32'h0);
    rd(12'hF14); chk("R7 hart id zero", cap_rd, 32'h0);
    rd(12'hC9F); chk("R7 hpm shadow zero", cap_rd, 32'h0);
    chk("R7 hpm shadow legal", cap_ill, 1'b0);
  endtask

  task automatic t_irq();
    rd(12'h344); chk("R11 global enable off", cap_take, 1'b0);
    step(SI, 12'h300, 32'h0, 5'd8, 1'b0);
    rd(12'h300); chk("R4 set enable", cap_rd, 32'h0000_1808);
    chk("R11 take sw", cap_take, 1'b1);
    chk("R11 sw before timer", cap_cause, 5'd3);
    set_irq(1'b1, 1'b1, 1'b1);
    rd(12'h344); chk("R11 ext first", cap_cause, 5'd11);
    step(C, 12'h304, 32'h0000_0800, 5'd7, 1'b0);
    rd(12'h304); chk("R11 ext masked", cap_cause, 5'd3);
    set_irq(1'b0, 1'b1, 1'b1);
    rd(12'h304); chk("R11 timer only", cap_cause, 5'd7);
    chk("R11 timer take", cap_take, 1'b1);
    set_irq(1'b0, 1'b0, 1'b1);
    rd(12'h304); chk("R11 ext not enabled", cap_take, 1'b0);
    set_irq(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_trap();
    do_trap(32'h0000_0100, 5'd2, 1'b0, 1'b0, 32'h0);
    chk("R9 exception target", cap_tt, 32'h0000_0008);
    rd(12'h341); chk("R8 epc saved", cap_rd, 32'h0000_0100);
    rd(12'h342); chk("R8 cause exception", cap_rd, 32'h0000_0002);
    rd(12'h300); chk("R8 enable moved", cap_rd, 32'h0000_1880);
    do_mret(); chk("R10 return target", cap_mt, 32'h0000_0100);
    rd(12'h300); chk("R10 enable restored", cap_rd, 32'h0000_1888);
    do_trap(32'h0000_0204, 5'd7, 1'b1, 1'b0, 32'h0);
    chk("R9 timer vector", cap_tt, 32'h0000_0024);
    rd(12'h342); chk("R8 cause interrupt bit", cap_rd, 32'h8000_0007);
    rd(12'h300); chk("R8 enable cleared", cap_rd, 32'h0000_1880);
    do_trap(32'h0000_0302, 5'd11, 1'b1, 1'b0, 32'h0);
    chk("R9 external vector", cap_tt, 32'h0000_0034);
    rd(12'h341); chk("R8 epc aligned on trap", cap_rd, 32'h0000_0300);
    rd(12'h300); chk("R8 nested trap status", cap_rd, 32'h0000_1800);
    do_mret();
    rd(12'h300); chk("R10 saved bit set", cap_rd, 32'h0000_1880);
    do_trap(32'h0000_0400, 5'd3, 1'b1, 1'b0, 32'h0);
    chk("R9 software vector", cap_tt, 32'h0000_0014);
  endtask

  task automatic t_prio();
    step(W, 12'h340, 32'h0000_0055, 5'd1, 1'b0);
    do_trap(32'h0000_0500, 5'd11, 1'b0, 1'b1, 32'h0000_0077);
    rd(12'h340); chk("R14 write discarded by trap", cap_rd, 32'h0000_0055);
    rd(12'h341); chk("R14 trap still taken", cap_rd, 32'h0000_0500);
    @(negedge clk);
    csr_req = 1'b1; csr_op = W; csr_addr = 12'h340; csr_src_val = 32'h99;
    csr_src_idx = 5'd1; trap_req = 1'b0; mret_req = 1'b1; retire = 1'b0;
    capture();
    rd(12'h340); chk("R14 write discarded by return", cap_rd, 32'h0000_0055);
  endtask

  task automatic t_counters();
    step(W, 12'hB80, 32'h0000_0005, 5'd1, 1'b0);
    step(W, 12'hB00, 32'hFFFF_FFFF, 5'd1, 1'b0);
    rd(12'hB00); chk("R13 low write replaces increment", cap_rd, 32'hFFFF_FFFF);
    rd(12'hB80); chk("R12 carry into high", cap_rd, 32'h0000_0006);
    rd(12'hC00); chk("R12 cycle shadow low", cap_rd, 32'h0000_0001);
    rd(12'hB00); chk("R12 cycle advances", cap_rd, 32'h0000_0002);
    rd(12'hC80); chk("R12 cycle shadow high", cap_rd, 32'h0000_0006);
    step(W, 12'hB02, 32'h0000_000A, 5'd1, 1'b1);
    step(S, 12'hB02, 32'h0, 5'd0, 1'b1); chk("R13 retire write wins", cap_rd, 32'h0000_000A);
    rd(12'hC02); chk("R12 retire counted", cap_rd, 32'h0000_000B);
    rd(12'hC02); chk("R12 no retire no count", cap_rd, 32'h0000_000B);
    step(W, 12'hB82, 32'h0000_0007, 5'd1, 1'b1);
    step(W, 12'hB02, 32'hFFFF_FFFF, 5'd1, 1'b0);
    step(S, 12'hB02, 32'h0, 5'd0, 1'b1); chk("R13 high write held low", cap_rd, 32'hFFFF_FFFF);
    rd(12'hC82); chk("R12 retire carry", cap_rd, 32'h0000_0008);
    rd(12'hB02); chk("R12 retire low wrapped", cap_rd, 32'h0);
    rd(12'hC01); chk("R12 time low", cap_rd, 32'h9ABC_DEF0);
    rd(12'hC81); chk("R12 time high", cap_rd, 32'h1234_5678);
  endtask

  initial begin
    rst_n = 1'b0; csr_req = 1'b0; csr_op = 3'b0; csr_addr = 12'h0;
    csr_src_val = 32'h0; csr_src_idx = 5'd0; retire = 1'b0;
    trap_req = 1'b0; trap_pc = 32'h0; trap_cause = 5'd0; trap_irq = 1'b0;
    mret_req = 1'b0; irq_sw_in = 1'b0; irq_tmr_in = 1'b0; irq_ext_in = 1'b0;
    mtime_in = 64'h1234_5678_9ABC_DEF0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ops();
    t_illegal();
    t_fields();
    t_irq();
    t_trap();
    t_prio();
    t_counters();
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule